// File: doc/BRIEF.md
# Paged Address Translation Map

This block sits between a network controller, a host and a small on-board RAM. The controller issues 24-bit word addresses. The block drops the top address bits, splits the rest into a page index and a byte offset, and looks the index up in a writable page map of 16-bit entries. Each entry supplies three things: a physical frame number, a byte-order choice, and a choice between on-board memory and an external expansion bus.

The host reaches the same map through a 16-bit register window that allows byte-lane writes. The host also has a memory window that goes through the same map, so both sides see one memory layout.

In the little-endian order, the two bytes of every controller data word are exchanged on the way to and from RAM. Host data always passes unchanged. An access whose frame number lies beyond the on-board RAM is suppressed and flagged. An access routed to the expansion bus is shown on a set of external request pins and does not touch the local array.

The parameter `NUM_FRAMES` sets how many 1024-byte frames the on-board RAM holds. A full-size board uses 256. The default of 4 keeps the array small for a compact configuration.

Top module: `pgx_top`

## Requirements
- R1: Bits 23:20 of the controller address have no effect. Two addresses that differ only in those bits reach the same memory word.
- R2: Address bits 9:0 are the byte offset and bits 19:10 index the page map. For an external access, `ext_addr` equals {entry bits 11:0, address bits 9:0}.
- R3: After reset every map entry reads 0. All-zero means frame 0, local memory, little-endian. After reset `c_rdata` is 0 and neither `c_oob` nor `ext_req` is asserted while idle.
- R4: Map entry i is read and written at register-window byte address 2*i while `h_sel_map`=1. `h_be[1]` enables bits 15:8 and `h_be[0]` enables bits 7:0. A read returns the stored entry one cycle later.
- R5: A map write changes translations starting with the next clock cycle. A controller access in the same cycle as the write still uses the old entry.
- R6: When entry bit 15 is 0, controller write data is byte-swapped into RAM and controller read data is byte-swapped out. When bit 15 is 1, data passes unchanged. The host memory window never swaps.
- R7: When entry bit 13 is 1, the controller access raises `ext_req` and `ext_we` follows `c_we`. Local RAM is not written, and a read returns 0.
- R8: With entry bit 13 at 0 and a frame number of at least `NUM_FRAMES`, the port's out-of-range flag is raised in the request cycle. Writes are dropped and reads return 0, on both the controller and host ports.
- R9: Two map entries may name the same frame and then alias it. The last entry covers controller address 0xFFFFF4, which lands at offset 0x3F4 of that entry's frame.
- R10: Read data appears on `c_rdata` and `h_rdata` in the cycle after the request. In a cycle that follows no read, `c_rdata` is 0.
- R11: Host memory writes honour `h_be` per byte lane and leave the other lane of the word intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_req | input | 1 | Controller access request |
| c_we | input | 1 | Controller write (1) or read (0) |
| c_addr | input | 24 | Controller byte address (bit 0 ignored, word access) |
| c_wdata | input | 16 | Controller write data |
| c_rdata | output | 16 | Controller read data, one cycle after request |
| c_oob | output | 1 | Controller frame out of range |
| ext_req | output | 1 | Controller access routed to expansion bus |
| ext_we | output | 1 | Expansion access is a write |
| ext_addr | output | 22 | Expansion physical address {frame, offset} |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_sel_map | input | 1 | Host targets the register window (1) or memory window (0) |
| h_be | input | 2 | Host byte enables, bit 1 = high byte |
| h_addr | input | 20 | Host byte address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, one cycle after request |
| h_oob | output | 1 | Host memory-window frame out of range |

## Verification
A corrupted map entry shows on the very next controller access through that page. It appears either as a wrong `ext_addr` frame field, as a spurious or missing `c_oob`/`ext_req` in the request cycle, or as a word that reads back from the wrong frame. A wrong swap state shows as reversed bytes when one frame is reached through two pages of opposite order. A write that escapes suppression shows only later, when the aliased frame is read back through a valid page. The bench therefore always plants a known word first and reads it back after the suppressed access.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  localparam int ENT_W     = 16;
  localparam int FRAME_W   = 12;
  localparam int ORDER_BIT = 15;
  localparam int EXT_BIT   = 13;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MAP  = 2'd1,
    RD_MEM  = 2'd2
  } rd_kind_e;

  function automatic logic [15:0] swap_bytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic logic [FRAME_W-1:0] ent_frame(input logic [ENT_W-1:0] e);
    return e[FRAME_W-1:0];
  endfunction

  function automatic logic ent_is_ext(input logic [ENT_W-1:0] e);
    return e[EXT_BIT];
  endfunction

  function automatic logic ent_is_le(input logic [ENT_W-1:0] e);
    return !e[ORDER_BIT];
  endfunction

endpackage

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
#(
  parameter int XLAT_W     = 20,
  parameter int OFF_W      = 10,
  parameter int NUM_FRAMES = 4,
  localparam int FR_AW     = $clog2(NUM_FRAMES),
  localparam int RAM_AW    = FR_AW + OFF_W - 1,
  localparam int PA_W      = FRAME_W + OFF_W
) (
  input  logic [XLAT_W-1:0] vaddr,
  input  logic [ENT_W-1:0]  ent,
  output logic [PA_W-1:0]   paddr,
  output logic [RAM_AW-1:0] word,
  output logic              is_ext,
  output logic              is_oob,
  output logic              is_swap
);

  logic [FRAME_W-1:0] frame;
  logic               unused_bits;

  assign frame   = ent_frame(ent);
  assign paddr   = {frame, vaddr[OFF_W-1:0]};
  assign word    = {frame[FR_AW-1:0], vaddr[OFF_W-1:1]};
  assign is_ext  = ent_is_ext(ent);
  assign is_oob  = !is_ext && (frame >= FRAME_W'(NUM_FRAMES));
  assign is_swap = ent_is_le(ent);

  assign unused_bits = ^{vaddr[XLAT_W-1:OFF_W], ent[ENT_W-2], ent[FRAME_W]};

endmodule

// File: rtl/pgx_map.sv
module pgx_map
  import pgx_pkg::*;
#(
  parameter int IDX_W  = 10,
  localparam int MAP_N = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_be,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] c_idx,
  output logic [ENT_W-1:0] c_ent,
  input  logic [IDX_W-1:0] h_idx,
  output logic [ENT_W-1:0] h_ent,
  input  logic [IDX_W-1:0] r_idx,
  output logic [ENT_W-1:0] r_ent
);

  logic [ENT_W-1:0] map_q [MAP_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAP_N; i++) map_q[i] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < 2; k++)
        if (wr_be[k]) map_q[wr_idx][k*8 +: 8] <= wr_data[k*8 +: 8];
    end
  end

  assign c_ent = map_q[c_idx];
  assign h_ent = map_q[h_idx];
  assign r_ent = map_q[r_idx];

  // R5: a full write is what the controller lookup sees one cycle later
  a_r5_map_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == 2'b11 && c_idx == wr_idx)
      |=> (c_idx != $past(wr_idx)) || (c_ent == $past(wr_data)));

  // R4: register-window lookup returns a freshly written entry
  a_r4_map_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == 2'b11 && r_idx == wr_idx)
      |=> (r_idx != $past(wr_idx)) || (r_ent == $past(wr_data)));

endmodule

// File: rtl/pgx_ram.sv
module pgx_ram #(
  parameter int AW      = 11,
  localparam int DEPTH  = 1 << AW
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [1:0]    a_be,
  input  logic [AW-1:0] a_addr,
  input  logic [15:0]   a_wdata,
  output logic [15:0]   a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [15:0]   b_wdata,
  output logic [15:0]   b_rdata
);

  logic [15:0] mem [DEPTH];

  // port b is written last, so it wins a same-word collision
  always_ff @(posedge clk) begin
    if (a_we)
      for (int k = 0; k < 2; k++)
        if (a_be[k]) mem[a_addr][k*8 +: 8] <= a_wdata[k*8 +: 8];
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/pgx_top.sv
module pgx_top
  import pgx_pkg::*;
#(
  parameter int VA_W       = 24,
  parameter int OFF_W      = 10,
  parameter int IDX_W      = 10,
  parameter int NUM_FRAMES = 4,
  localparam int XLAT_W    = OFF_W + IDX_W,
  localparam int FR_AW     = $clog2(NUM_FRAMES),
  localparam int RAM_AW    = FR_AW + OFF_W - 1,
  localparam int PA_W      = FRAME_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_req,
  input  logic              c_we,
  input  logic [VA_W-1:0]   c_addr,
  input  logic [15:0]       c_wdata,
  output logic [15:0]       c_rdata,
  output logic              c_oob,
  output logic              ext_req,
  output logic              ext_we,
  output logic [PA_W-1:0]   ext_addr,
  input  logic              h_req,
  input  logic              h_we,
  input  logic              h_sel_map,
  input  logic [1:0]        h_be,
  input  logic [XLAT_W-1:0] h_addr,
  input  logic [15:0]       h_wdata,
  output logic [15:0]       h_rdata,
  output logic              h_oob
);

  localparam int NPORT = 2; // 0 = controller, 1 = host memory window

  logic [XLAT_W-1:0] x_va    [NPORT];
  logic [ENT_W-1:0]  x_ent   [NPORT];
  logic [PA_W-1:0]   x_pa    [NPORT];
  logic [RAM_AW-1:0] x_word  [NPORT];
  logic              x_ext   [NPORT];
  logic              x_oob   [NPORT];
  logic              x_swap  [NPORT];

  logic [ENT_W-1:0]  r_ent;
  logic              map_wr;
  logic              c_local, h_local, h_mem;
  logic              c_ram_we, h_ram_we;
  logic [15:0]       c_ram_wd, c_rd_raw, h_rd_raw;
  logic              c_pend_q, c_swap_q;
  rd_kind_e          h_kind_q;
  logic [15:0]       h_map_q;
  logic              unused_bits;

  assign x_va[0] = c_addr[XLAT_W-1:0];
  assign x_va[1] = h_addr;
  assign map_wr  = h_req && h_we && h_sel_map;

  pgx_map #(.IDX_W(IDX_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr),
    .wr_idx  (h_addr[IDX_W:1]),
    .wr_be   (h_be),
    .wr_data (h_wdata),
    .c_idx   (c_addr[XLAT_W-1:OFF_W]),
    .c_ent   (x_ent[0]),
    .h_idx   (h_addr[XLAT_W-1:OFF_W]),
    .h_ent   (x_ent[1]),
    .r_idx   (h_addr[IDX_W:1]),
    .r_ent   (r_ent)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_xl
    pgx_xlate #(.XLAT_W(XLAT_W), .OFF_W(OFF_W), .NUM_FRAMES(NUM_FRAMES)) u_xl (
      .vaddr   (x_va[p]),
      .ent     (x_ent[p]),
      .paddr   (x_pa[p]),
      .word    (x_word[p]),
      .is_ext  (x_ext[p]),
      .is_oob  (x_oob[p]),
      .is_swap (x_swap[p])
    );
  end

  // controller side
  assign c_local  = !x_ext[0] && !x_oob[0];
  assign c_ram_we = c_req && c_we && c_local;
  assign c_ram_wd = x_swap[0] ? swap_bytes(c_wdata) : c_wdata;
  assign c_oob    = c_req && x_oob[0];
  assign ext_req  = c_req && x_ext[0];
  assign ext_we   = c_req && c_we && x_ext[0];
  assign ext_addr = x_pa[0];

  // host side
  assign h_mem    = h_req && !h_sel_map;
  assign h_local  = !x_ext[1] && !x_oob[1];
  assign h_ram_we = h_mem && h_we && h_local;
  assign h_oob    = h_mem && x_oob[1];

  pgx_ram #(.AW(RAM_AW)) u_ram (
    .clk     (clk),
    .a_we    (h_ram_we),
    .a_be    (h_be),
    .a_addr  (x_word[1]),
    .a_wdata (h_wdata),
    .a_rdata (h_rd_raw),
    .b_we    (c_ram_we),
    .b_addr  (x_word[0]),
    .b_wdata (c_ram_wd),
    .b_rdata (c_rd_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_pend_q <= 1'b0;
      c_swap_q <= 1'b0;
      h_kind_q <= RD_NONE;
      h_map_q  <= '0;
    end else begin
      c_pend_q <= c_req && !c_we && c_local;
      c_swap_q <= x_swap[0];
      h_map_q  <= r_ent;
      if (h_req && !h_we)
        h_kind_q <= h_sel_map ? RD_MAP : (h_local ? RD_MEM : RD_NONE);
      else
        h_kind_q <= RD_NONE;
    end
  end

  assign c_rdata = c_pend_q ? (c_swap_q ? swap_bytes(c_rd_raw) : c_rd_raw) : '0;

  always_comb begin
    case (h_kind_q)
      RD_MAP:  h_rdata = h_map_q;
      RD_MEM:  h_rdata = h_rd_raw;
      default: h_rdata = '0;
    endcase
  end

  assign unused_bits = ^{c_addr[VA_W-1:XLAT_W], x_pa[1]};

  // R8: an out-of-range controller read delivers zero
  a_r8_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (c_req && !c_we && c_oob) |=> (c_rdata == '0));

  // R7: an expansion-bus read leaves the local data path at zero
  a_r7_ext_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_we) |=> (c_rdata == '0));

  // R8: the range flag only concerns on-board accesses
  a_r8_oob_not_ext: assert property (@(posedge clk) disable iff (!rst_n)
    c_oob |-> !ext_req);

  // R8: host out-of-range writes never reach the array
  a_r8_host_oob_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    h_oob |-> !h_ram_we);

endmodule

// File: tb/sim_pgx_top.sv
module sim_pgx_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c_req = 1'b0, c_we = 1'b0;
  logic [23:0] c_addr = '0;
  logic [15:0] c_wdata = '0;
  logic [15:0] c_rdata;
  logic        c_oob, ext_req, ext_we;
  logic [21:0] ext_addr;
  logic        h_req = 1'b0, h_we = 1'b0, h_sel_map = 1'b0;
  logic [1:0]  h_be = 2'b11;
  logic [19:0] h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic        h_oob;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pgx_top u0 (
    .clk(clk), .rst_n(rst_n),
    .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(c_rdata), .c_oob(c_oob), .ext_req(ext_req), .ext_we(ext_we),
    .ext_addr(ext_addr),
    .h_req(h_req), .h_we(h_we), .h_sel_map(h_sel_map), .h_be(h_be),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_oob(h_oob)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic map_wr(input int idx, input logic [15:0] v, input logic [1:0] be);
    @(negedge clk);
    h_req = 1; h_we = 1; h_sel_map = 1; h_be = be; h_addr = 20'(idx * 2); h_wdata = v;
    @(negedge clk);
    h_req = 0; h_we = 0; h_sel_map = 0; h_be = 2'b11;
  endtask

  task automatic map_rd(input int idx, output logic [15:0] v);
    @(negedge clk);
    h_req = 1; h_we = 0; h_sel_map = 1; h_addr = 20'(idx * 2);
    @(negedge clk);
    v = h_rdata;
    h_req = 0; h_sel_map = 0;
  endtask

  task automatic hm_op(input logic we, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] be, output logic [15:0] rd, output logic oob);
    @(negedge clk);
    h_req = 1; h_we = we; h_sel_map = 0; h_be = be; h_addr = a; h_wdata = d;
    #1 oob = h_oob;
    @(negedge clk);
    rd = h_rdata;
    h_req = 0; h_we = 0; h_be = 2'b11;
  endtask

  task automatic c_op(input logic we, input logic [23:0] a, input logic [15:0] d,
                      output logic [15:0] rd, output logic oob, output logic ext,
                      output logic [21:0] ea);
    @(negedge clk);
    c_req = 1; c_we = we; c_addr = a; c_wdata = d;
    #1 oob = c_oob; ext = ext_req; ea = ext_addr;
    @(negedge clk);
    rd = c_rdata;
    c_req = 0; c_we = 0;
  endtask

  initial begin
    logic [15:0] v, rd;
    logic oob, ext;
    logic [21:0] ea;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R3: reset state
    chk(c_rdata == 0, "R3 idle c_rdata", c_rdata, 0);
    chk(!c_oob && !ext_req, "R3 idle flags", {c_oob, ext_req}, 0);
    map_rd(0, v);    chk(v == 0, "R3 entry 0", v, 0);
    map_rd(517, v);  chk(v == 0, "R3 entry 517", v, 0);
    map_rd(1023, v); chk(v == 0, "R3 entry 1023", v, 0);
    c_op(1, 24'h000004, 16'h1234, rd, oob, ext, ea);
    chk(!oob && !ext, "R3 zero entry is local", {oob, ext}, 0);
    c_op(0, 24'h000004, 0, rd, oob, ext, ea);
    chk(rd == 16'h1234, "R3 zero entry readback", rd, 16'h1234);
    @(negedge clk);
    chk(c_rdata == 0, "R10 no read gives zero", c_rdata, 0);

    // R4: full register-window sweep
    for (int i = 0; i < 1024; i++) map_wr(i, 16'(i * 40503) ^ 16'h5A5A, 2'b11);
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] e;
      e = 16'(i * 40503) ^ 16'h5A5A;
      map_rd(i, v);
      chk(v == e, $sformatf("R4 entry %0d", i), v, e);
    end
    map_wr(7, 16'hFFFF, 2'b11);
    map_wr(7, 16'h1200, 2'b10);
    map_rd(7, v); chk(v == 16'h12FF, "R4 high lane", v, 16'h12FF);
    map_wr(7, 16'h0034, 2'b01);
    map_rd(7, v); chk(v == 16'h1234, "R4 low lane", v, 16'h1234);

    // R1 R2 R7 R8: translation sweep over every page
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] e, d;
      logic [9:0] off;
      logic [23:0] a;
      int fr;
      fr  = (i >> 2) & 7;
      e   = ((i & 1) != 0 ? 16'h8000 : 16'h0) | ((i & 2) != 0 ? 16'h2000 : 16'h0) | 16'(fr);
      off = 10'((i * 6) & 'h3FE);
      a   = {4'(i), 10'(i), off};
      d   = 16'(i * 257) ^ 16'h5AA5;
      map_wr(i, e, 2'b11);
      c_op(1, a, d, rd, oob, ext, ea);
      if ((i & 2) != 0) begin
        chk(ext && !oob, $sformatf("R7 page %0d ext flag", i), {ext, oob}, 2'b10);
        chk(ea == {12'(fr), off}, $sformatf("R2 page %0d ext_addr", i), ea, {12'(fr), off});
      end else if (fr >= 4) begin
        chk(oob && !ext, $sformatf("R8 page %0d oob flag", i), {ext, oob}, 2'b01);
      end else begin
        chk(!oob && !ext, $sformatf("R2 page %0d local flags", i), {ext, oob}, 0);
      end
      c_op(0, a, 0, rd, oob, ext, ea);
      if ((i & 2) != 0 || fr >= 4)
        chk(rd == 0, $sformatf("R8 page %0d read zero", i), rd, 0);
      else
        chk(rd == d, $sformatf("R1 page %0d readback", i), rd, d);
    end

    // identity pages 0..3, big-endian, local
    for (int i = 0; i < 4; i++) map_wr(i, 16'h8000 | 16'(i), 2'b11);

    // R6: byte order through two pages on frame 0
    map_wr(8, 16'h0000, 2'b11);
    map_wr(9, 16'h8000, 2'b11);
    c_op(1, 24'h002010, 16'h1234, rd, oob, ext, ea);
    c_op(0, 24'h002410, 0, rd, oob, ext, ea);
    chk(rd == 16'h3412, "R6 LE write seen BE", rd, 16'h3412);
    hm_op(0, 20'h00010, 0, 2'b11, rd, oob);
    chk(rd == 16'h3412, "R6 host sees stored order", rd, 16'h3412);
    c_op(1, 24'h002412, 16'hABCD, rd, oob, ext, ea);
    c_op(0, 24'h002012, 0, rd, oob, ext, ea);
    chk(rd == 16'hCDAB, "R6 BE write seen LE", rd, 16'hCDAB);
    hm_op(0, 20'h00012, 0, 2'b11, rd, oob);
    chk(rd == 16'hABCD, "R6 host no swap", rd, 16'hABCD);

    // R11: host byte lanes
    hm_op(1, 20'h00400, 16'h1234, 2'b11, rd, oob);
    hm_op(1, 20'h00400, 16'hAB00, 2'b10, rd, oob);
    hm_op(0, 20'h00400, 0, 2'b11, rd, oob);
    chk(rd == 16'hAB34, "R11 high lane only", rd, 16'hAB34);
    hm_op(1, 20'h00400, 16'h00CD, 2'b01, rd, oob);
    hm_op(0, 20'h00400, 0, 2'b11, rd, oob);
    chk(rd == 16'hABCD, "R11 low lane only", rd, 16'hABCD);

    // R8: out-of-range frame 5 must not alias frame 1
    hm_op(1, 20'h00420, 16'h1111, 2'b11, rd, oob);
    map_wr(10, 16'h8005, 2'b11);
    c_op(1, 24'h002820, 16'h9999, rd, oob, ext, ea);
    chk(oob == 1, "R8 ctrl oob flag", oob, 1);
    hm_op(1, 20'h02820, 16'h7777, 2'b11, rd, oob);
    chk(oob == 1, "R8 host oob flag", oob, 1);
    hm_op(0, 20'h02820, 0, 2'b11, rd, oob);
    chk(rd == 0, "R8 host oob read zero", rd, 0);
    hm_op(0, 20'h00420, 0, 2'b11, rd, oob);
    chk(rd == 16'h1111, "R8 frame 1 untouched", rd, 16'h1111);

    // R7: expansion route leaves frame 1 alone
    map_wr(11, 16'hA001, 2'b11);
    c_op(1, 24'h002C20, 16'h8888, rd, oob, ext, ea);
    chk(ext == 1 && ea == 22'h000420, "R7 ext request", {ext, ea}, {1'b1, 22'h000420});
    hm_op(0, 20'h00420, 0, 2'b11, rd, oob);
    chk(rd == 16'h1111, "R7 local untouched", rd, 16'h1111);

    // R5: map write and controller access in the same cycle
    map_wr(5, 16'h8003, 2'b11);
    @(negedge clk);
    h_req = 1; h_we = 1; h_sel_map = 1; h_be = 2'b11; h_addr = 20'(5 * 2); h_wdata = 16'h8002;
    c_req = 1; c_we = 1; c_addr = 24'h001430; c_wdata = 16'hAAAA;
    @(negedge clk);
    h_req = 0; h_we = 0; h_sel_map = 0;
    c_wdata = 16'hBBBB;
    @(negedge clk);
    c_req = 0; c_we = 0;
    hm_op(0, 20'h00C30, 0, 2'b11, rd, oob);
    chk(rd == 16'hAAAA, "R5 same cycle uses old entry", rd, 16'hAAAA);
    hm_op(0, 20'h00830, 0, 2'b11, rd, oob);
    chk(rd == 16'hBBBB, "R5 next cycle uses new entry", rd, 16'hBBBB);

    // R9: last page double-mapped onto frame 0
    map_wr(1023, 16'h8000, 2'b11);
    c_op(1, 24'hFFFFF4, 16'h5151, rd, oob, ext, ea);
    hm_op(0, 20'h003F4, 0, 2'b11, rd, oob);
    chk(rd == 16'h5151, "R9 alias host view", rd, 16'h5151);
    c_op(0, 24'h0003F4, 0, rd, oob, ext, ea);
    chk(rd == 16'h5151, "R9 alias ctrl view", rd, 16'h5151);

    // R1: top nibble ignored
    c_op(1, 24'h000C40, 16'h2468, rd, oob, ext, ea);
    c_op(0, 24'h700C40, 0, rd, oob, ext, ea);
    chk(rd == 16'h2468, "R1 top bits ignored", rd, 16'h2468);

    // R10: idle after reads returns zero
    @(negedge clk);
    chk(c_rdata == 0, "R10 idle zero", c_rdata, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule